// File: doc/BRIEF.md
# Cache Block Refill Sequencer

After a cache miss, one whole block has to be brought in from main memory. This block produces that refill schedule. It issues the address phases on the memory bus and marks every data-return beat with the index of the word being delivered. It also counts the cycles spent, so the exact miss penalty of the chosen memory organisation can be read out once the refill ends. The memory arrays themselves and the cache data path sit outside the block.

Three memory organisations are supported, picked per refill by a mode input:
- a memory and bus one word wide;
- a memory and bus four words wide;
- four interleaved banks sharing a bus one word wide.

In each case, sending an address costs one cycle and memory latency costs ten cycles. Each transfer on the bus costs one cycle. A refill starts with a one-cycle start strobe that carries the block base address. It ends with a one-cycle done pulse, and the cycle total stays readable after that pulse.

Top module: `blkfill_seq`

## Requirements
- R1: While reset is held and just after it is released, busy, done, the address strobe and the data strobe are all low, and the cycle count reads 0.
- R2: When mode is 2'b00, and also when it is 2'b11, a refill runs as 16 transactions. Each transaction is one address cycle, then ten latency cycles, then one data beat of one word. The refill totals 192 cycles.
- R3: When mode is 2'b01, a refill runs as 4 transactions of 12 cycles each: one address cycle, ten latency cycles and one data beat. Each beat carries four words, and its index gives the first of them (0, 4, 8, 12). The refill totals 48 cycles.
- R4: When mode is 2'b10, a refill runs as 4 transactions. Each is one address cycle, ten latency cycles, then four data beats on consecutive cycles. The refill totals 60 cycles.
- R5: The bus address in each address cycle is the block base with its low four bits cleared, plus the index of the first word in that transaction. The low four bits of the supplied base have no effect.
- R6: Across a refill, the data beat word indices rise strictly in address order, starting at 0 and covering all 16 words exactly once.
- R7: A start strobe is ignored while busy is high, including during the done cycle. The running refill keeps its base, its mode and its schedule.
- R8: Busy goes high in the cycle after an accepted start and stays high through the done cycle, then drops. Done is a single-cycle pulse in the cycle right after the last data beat.
- R9: The cycle count covers every cycle from the first address cycle through the last data cycle, inclusive. It equals the refill total during the done cycle and holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a refill |
| base_addr_i | input | ADDR_W | Word address of the block to refill |
| mode_i | input | 2 | Memory organisation: 00 narrow, 01 wide, 10 interleaved, 11 narrow |
| busy_o | output | 1 | Refill in progress |
| mem_addr_valid_o | output | 1 | Address phase on the memory bus this cycle |
| mem_addr_o | output | ADDR_W | Word address driven in the address phase |
| data_beat_o | output | 1 | Data is returned on the bus this cycle |
| beat_word_o | output | 4 | Index within the block of the (first) word in this beat |
| done_o | output | 1 | One-cycle pulse when the refill completes |
| cycle_count_o | output | CNT_W | Cycles spent on the refill, held after done |

## Verification
A corrupted latency counter shifts every data beat away from eleven cycles after its address cycle. It also pushes done and the total off the expected value, and this shows up in the first transaction. A wrong word or beat step shows up at once as a word index that is out of order or skipped, and as an address that is wrong at the next address cycle. It also changes the number of transactions, which the done time exposes. If the base or the mode were loaded while busy, an ignored start would redirect a running refill, and later addresses or the beat pattern would show it. A counter that slips is caught by the total read in the done cycle, and by the hold check a few cycles later.

// File: rtl/blkfill_pkg.sv
package blkfill_pkg;

    typedef enum logic [1:0] {
        MODE_NARROW = 2'b00,
        MODE_WIDE   = 2'b01,
        MODE_INTLV  = 2'b10,
        MODE_ALT    = 2'b11
    } fill_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_XFER,
        ST_DONE
    } fill_state_e;

endpackage

// File: rtl/blkfill_sched.sv
module blkfill_sched
    import blkfill_pkg::*;
#(
    parameter int WIDE_WORDS = 4,
    parameter int BANKS      = 4,
    parameter int WIDX_W     = 5,
    parameter int BEAT_W     = 3
) (
    input  logic [1:0]        mode_i,
    output logic [WIDX_W-1:0] words_per_beat_o,
    output logic [BEAT_W-1:0] beats_per_txn_o
);

    always_comb begin
        words_per_beat_o = WIDX_W'(1);
        beats_per_txn_o  = BEAT_W'(1);
        case (fill_mode_e'(mode_i))
            MODE_WIDE: begin
                words_per_beat_o = WIDX_W'(WIDE_WORDS);
                beats_per_txn_o  = BEAT_W'(1);
            end
            MODE_INTLV: begin
                words_per_beat_o = WIDX_W'(1);
                beats_per_txn_o  = BEAT_W'(BANKS);
            end
            default: begin
                words_per_beat_o = WIDX_W'(1);
                beats_per_txn_o  = BEAT_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/blkfill_addr_gen.sv
module blkfill_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_WORDS = 16,
    parameter int IDX_W       = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  word_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_WORDS - 1);

    always_comb begin
        addr_o = (base_i & ALIGN_MASK) | ADDR_W'(word_i);
    end

endmodule

// File: rtl/blkfill_cycle_ctr.sv
module blkfill_cycle_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    // R9: each counted cycle adds exactly one
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && !clear_i |=> count_o == $past(count_o) + CNT_W'(1));

    // R9: outside counted cycles the total is held
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i && !clear_i |=> $stable(count_o));

endmodule

// File: rtl/blkfill_seq.sv
module blkfill_seq
    import blkfill_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_WORDS = 16,
    parameter int MEM_LATENCY = 10,
    parameter int WIDE_WORDS  = 4,
    parameter int BANKS       = 4,
    localparam int IDX_W      = $clog2(BLOCK_WORDS),
    localparam int CNT_W      = $clog2(BLOCK_WORDS * (MEM_LATENCY + 2) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [1:0]        mode_i,
    output logic              busy_o,
    output logic              mem_addr_valid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              data_beat_o,
    output logic [IDX_W-1:0]  beat_word_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cycle_count_o
);

    localparam int WIDX_W = IDX_W + 1;
    localparam int BEAT_W = $clog2(BANKS + 1);
    localparam int LAT_W  = $clog2(MEM_LATENCY + 1);

    typedef struct packed {
        fill_state_e       st;
        logic [ADDR_W-1:0] base;
        logic [1:0]        mode;
        logic [WIDX_W-1:0] word;
        logic [BEAT_W-1:0] beat;
        logic [LAT_W-1:0]  wait_left;
    } seq_t;

    seq_t seq_d, seq_q;
    logic              ctr_clear, ctr_inc;
    logic [WIDX_W-1:0] words_per_beat;
    logic [BEAT_W-1:0] beats_per_txn;
    logic [WIDX_W-1:0] word_next;

    blkfill_sched #(
        .WIDE_WORDS (WIDE_WORDS),
        .BANKS      (BANKS),
        .WIDX_W     (WIDX_W),
        .BEAT_W     (BEAT_W)
    ) u_sched (
        .mode_i           (seq_q.mode),
        .words_per_beat_o (words_per_beat),
        .beats_per_txn_o  (beats_per_txn)
    );

    blkfill_addr_gen #(
        .ADDR_W      (ADDR_W),
        .BLOCK_WORDS (BLOCK_WORDS),
        .IDX_W       (IDX_W)
    ) u_addr (
        .base_i (seq_q.base),
        .word_i (seq_q.word[IDX_W-1:0]),
        .addr_o (mem_addr_o)
    );

    blkfill_cycle_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ctr_clear),
        .inc_i   (ctr_inc),
        .count_o (cycle_count_o)
    );

    assign word_next = seq_q.word + words_per_beat;

    always_comb begin
        seq_d     = seq_q;
        ctr_clear = 1'b0;
        ctr_inc   = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st   = ST_ADDR;
                    seq_d.base = base_addr_i;
                    seq_d.mode = mode_i;
                    seq_d.word = '0;
                    seq_d.beat = '0;
                    ctr_clear  = 1'b1;
                end
            end
            ST_ADDR: begin
                ctr_inc         = 1'b1;
                seq_d.st        = ST_WAIT;
                seq_d.wait_left = LAT_W'(MEM_LATENCY - 1);
            end
            ST_WAIT: begin
                ctr_inc = 1'b1;
                if (seq_q.wait_left == '0) begin
                    seq_d.st   = ST_XFER;
                    seq_d.beat = '0;
                end else begin
                    seq_d.wait_left = seq_q.wait_left - LAT_W'(1);
                end
            end
            ST_XFER: begin
                ctr_inc    = 1'b1;
                seq_d.word = word_next;
                seq_d.beat = seq_q.beat + BEAT_W'(1);
                if (seq_q.beat == beats_per_txn - BEAT_W'(1)) begin
                    if (word_next == WIDX_W'(BLOCK_WORDS)) begin
                        seq_d.st = ST_DONE;
                    end else begin
                        seq_d.st = ST_ADDR;
                    end
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, base: '0, mode: '0, word: '0, beat: '0, wait_left: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o           = (seq_q.st != ST_IDLE);
    assign mem_addr_valid_o = (seq_q.st == ST_ADDR);
    assign data_beat_o      = (seq_q.st == ST_XFER);
    assign beat_word_o      = seq_q.word[IDX_W-1:0];
    assign done_o           = (seq_q.st == ST_DONE);

    // R8: done lasts one cycle and releases busy
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R2: an address cycle is never followed directly by data
    a_r2_addr_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_valid_o |=> !data_beat_o && busy_o);

    // R6: beat indices stay inside the block
    a_r6_beat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        data_beat_o |-> seq_q.word < WIDX_W'(BLOCK_WORDS));

    // R7: a running refill keeps its base and mode
    a_r7_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(seq_q.base) && $stable(seq_q.mode));

    // R9: total at done matches the schedule of the latched mode
    a_r9_total: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> int'(cycle_count_o) ==
            (BLOCK_WORDS / (int'(words_per_beat) * int'(beats_per_txn)))
            * (MEM_LATENCY + 1 + int'(beats_per_txn)));

endmodule

// File: tb/blkfill_seq_test.sv
module blkfill_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [1:0]  mode_i = '0;
    logic        busy_o, mem_addr_valid_o, data_beat_o, done_o;
    logic [31:0] mem_addr_o;
    logic [3:0]  beat_word_o;
    logic [7:0]  cycle_count_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int          cyc = 0;
    int          na = 0, nb = 0, nd = 0, nbusy = 0;
    int          a_cyc [32];
    logic [31:0] a_val [32];
    int          b_cyc [64];
    int          b_idx [64];
    int          d_cyc = 0;
    int          count_at_done = 0;

    blkfill_seq uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .base_addr_i      (base_addr_i),
        .mode_i           (mode_i),
        .busy_o           (busy_o),
        .mem_addr_valid_o (mem_addr_valid_o),
        .mem_addr_o       (mem_addr_o),
        .data_beat_o      (data_beat_o),
        .beat_word_o      (beat_word_o),
        .done_o           (done_o),
        .cycle_count_o    (cycle_count_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (busy_o) nbusy = nbusy + 1;
        if (mem_addr_valid_o && na < 32) begin
            a_cyc[na] = cyc;
            a_val[na] = mem_addr_o;
            na = na + 1;
        end
        if (data_beat_o && nb < 64) begin
            b_cyc[nb] = cyc;
            b_idx[nb] = int'(beat_word_o);
            nb = nb + 1;
        end
        if (done_o) begin
            d_cyc = cyc;
            count_at_done = int'(cycle_count_o);
            nd = nd + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        na = 0; nb = 0; nd = 0; nbusy = 0;
    endtask

    task automatic pulse_start(input logic [1:0] m, input logic [31:0] b);
        @(posedge clk); #1;
        start_i = 1'b1; mode_i = m; base_addr_i = b;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (nd == 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Compare the logged schedule with the one the requirements give for mode m.
    task automatic verify(input logic [1:0] m, input logic [31:0] b, input string req);
        int wpb, bpt, txns, per, total, t0;
        logic [31:0] aligned;
        wpb = (m == 2'b01) ? 4 : 1;
        bpt = (m == 2'b10) ? 4 : 1;
        txns = 16 / (wpb * bpt);
        per = 11 + bpt;
        total = txns * per;
        aligned = b & 32'hFFFF_FFF0;
        check(na == txns, {req, " address cycle count"}, na, txns);
        check(nb == txns * bpt, {req, " beat count (R6)"}, nb, txns * bpt);
        t0 = (na > 0) ? a_cyc[0] : 0;
        for (int t = 0; t < txns && t < na; t++) begin
            check(a_cyc[t] - t0 == t * per, {req, " address timing"}, a_cyc[t] - t0, t * per);
            check(a_val[t] == aligned + 32'(t * wpb * bpt), {req, " R5 address"},
                  a_val[t], aligned + 32'(t * wpb * bpt));
        end
        for (int t = 0; t < txns; t++) begin
            for (int k = 0; k < bpt; k++) begin
                int j = t * bpt + k;
                if (j < nb) begin
                    check(b_cyc[j] - t0 == t * per + 11 + k, {req, " beat timing"},
                          b_cyc[j] - t0, t * per + 11 + k);
                    check(b_idx[j] == j * wpb, {req, " R6 word index"}, b_idx[j], j * wpb);
                end
            end
        end
        check(nd == 1, {req, " R8 single done"}, nd, 1);
        check(d_cyc - t0 == total, {req, " R8 done timing"}, d_cyc - t0, total);
        check(count_at_done == total, {req, " R9 total at done"}, count_at_done, total);
        check(nbusy == total + 1, {req, " R8 busy length"}, nbusy, total + 1);
        check(!busy_o, {req, " R8 busy dropped"}, busy_o, 0);
        check(int'(cycle_count_o) == total, {req, " R9 count held"}, cycle_count_o, total);
    endtask

    task automatic test_reset();
        check(!busy_o && !done_o, "R1 busy/done low", {busy_o, done_o}, 0);
        check(!mem_addr_valid_o && !data_beat_o, "R1 strobes low", {mem_addr_valid_o, data_beat_o}, 0);
        check(cycle_count_o == 0, "R1 count zero", cycle_count_o, 0);
    endtask

    task automatic test_narrow();
        clear_logs();
        pulse_start(2'b00, 32'h0000_1000);
        wait_done();
        verify(2'b00, 32'h0000_1000, "R2 narrow");
    endtask

    task automatic test_wide();
        clear_logs();
        pulse_start(2'b01, 32'h0000_2340);
        wait_done();
        verify(2'b01, 32'h0000_2340, "R3 wide");
    endtask

    task automatic test_intlv();
        clear_logs();
        pulse_start(2'b10, 32'h000A_BCD0);
        wait_done();
        verify(2'b10, 32'h000A_BCD0, "R4 interleaved");
    endtask

    task automatic test_alt_unaligned();
        clear_logs();
        pulse_start(2'b11, 32'h0000_1237);
        wait_done();
        verify(2'b00, 32'h0000_1237, "R2 mode 11 / R5 unaligned");
    endtask

    task automatic test_busy_ignore();
        clear_logs();
        pulse_start(2'b10, 32'h0000_0400);
        repeat (20) @(negedge clk);
        pulse_start(2'b00, 32'h0000_9990);
        while (!done_o) @(negedge clk);
        #1 start_i = 1'b1; mode_i = 2'b01; base_addr_i = 32'h0000_7770;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        verify(2'b10, 32'h0000_0400, "R7 ignored starts");
        check(!busy_o, "R7 start in done cycle ignored", busy_o, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_narrow();
        test_wide();
        test_intlv();
        test_alt_unaligned();
        test_busy_ignore();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

endmodule